// File: doc/BRIEF.md
# Power-Down Output Gating Controller

This block sits between a set of free-running clock sources and the pins that carry them. It watches an asynchronous active-low power-down request and decides, one output at a time, when each clock may toggle. The request is sampled on the CPU clock. A power-down is accepted only after two consecutive low samples. Each output is then parked low at its own next falling edge, so no high phase is ever cut short. While the device is down, stop requests to the crystal oscillator and to the PLL are raised.

When the request goes away, the stop requests fall first. The outputs stay parked for a programmable number of CPU-clock cycles so the oscillator and PLL can settle. After that, each output starts again on its own falling edge.

Outside power-down, a per-output enable vector from the configuration registers can park individual outputs. Outputs marked free-running at build time ignore that vector. The same settle sequence also runs out of reset, so no output toggles before the settle count has elapsed.

Top module: `pdg_ctrl`

## Requirements
- R1: During reset and for at least SETTLE_CYC CPU-clock cycles after reset release, `osc_stop` and `vco_stop` are 0 and every bit of `clk_out` stays low.
- R2: When `pd_n` is low at two consecutive rising edges of `cpu_clk`, both stop requests go to 1 after the next rising edge, which is the third edge counted from the first low sample. They stay at 0 before that edge.
- R3: A low level on `pd_n` that is sampled at only one rising edge of `cpu_clk` does not start power-down. The stop requests stay 0 and the outputs keep toggling.
- R4: While the stop requests are 1, every output is held low once its source has passed a falling edge. This includes the free-running outputs.
- R5: Gating never shortens a pulse. Every high pulse seen on `clk_out[i]` lasts exactly the high time of `clk_in[i]`.
- R6: In power-down, once `pd_n` is sampled high at a rising edge of `cpu_clk`, both stop requests return to 0 after the following rising edge.
- R7: After the stop requests fall, all outputs stay low for SETTLE_CYC CPU-clock cycles. After that, each enabled output resumes toggling.
- R8: `reg_en[i]` = 0 holds `clk_out[i]` low and `reg_en[i]` = 1 lets it run. Bit i controls output i.
- R9: Outputs whose bit is set in FREE_MASK (default 4'b0100, so output 2) toggle whatever the value of their `reg_en` bit.
- R10: A power-down request that is accepted during the settle interval re-enters power-down with the same two-sample rule as R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cpu_clk | input | 1 | Sampling clock for the power-down request and the sequencer |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pd_n | input | 1 | Asynchronous active-low power-down request |
| clk_in | input | NUM_OUT | Ungated source clocks, one per output |
| reg_en | input | NUM_OUT | Per-output enables from the configuration registers, 1 = run |
| clk_out | output | NUM_OUT | Gated output clocks |
| osc_stop | output | 1 | Request to stop the crystal oscillator |
| vco_stop | output | 1 | Request to stop the PLL VCOs |

## Verification
Two functions can land in the same cycle: the sequencer can accept a new power-down request in the very cycle that it counts down the settle interval from the previous release. The bench provokes this by driving `pd_n` low immediately after the stop requests drop. It then checks, edge by edge, that the stop requests come back exactly on the third rising edge and that no output escapes between the two phases. A second collision occurs when a register enable changes while the power-down sequencer is idle. The bench judges this by measuring each output's activity over a window and by timing every high pulse against its source's high time.

// File: rtl/pdg_pkg.sv
`timescale 1ns/1ps
package pdg_pkg;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_DOWN   = 2'd1,
    ST_SETTLE = 2'd2
  } pdg_state_e;

endpackage

// File: rtl/pdg_pd_sampler.sv
`timescale 1ns/1ps
module pdg_pd_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_n,
  output logic accept,
  output logic release_seen
);

  logic smp_now_q;
  logic smp_prev_q;

  // Two sample stages; reset treats the request as inactive.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_now_q  <= 1'b1;
      smp_prev_q <= 1'b1;
    end else begin
      smp_now_q  <= pd_n;
      smp_prev_q <= smp_now_q;
    end
  end

  assign accept       = !smp_now_q && !smp_prev_q;
  assign release_seen = smp_now_q;

endmodule

// File: rtl/pdg_seq.sv
`timescale 1ns/1ps
module pdg_seq
  import pdg_pkg::*;
#(
  parameter int SETTLE_CYC = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic release_seen,
  output logic run_grant,
  output logic stop_req
);

  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] SETTLE_LOAD = CW'(SETTLE_CYC - 1);

  pdg_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (accept) state_d = ST_DOWN;
      end
      ST_DOWN: begin
        if (release_seen) begin
          state_d = ST_SETTLE;
          cnt_d   = SETTLE_LOAD;
          cnt_en  = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (accept) begin
          state_d = ST_DOWN;
        end else if (cnt_q == '0) begin
          state_d = ST_RUN;
        end else begin
          cnt_d  = cnt_q - 1'b1;
          cnt_en = 1'b1;
        end
      end
      default: state_d = ST_DOWN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SETTLE;
      cnt_q   <= SETTLE_LOAD;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign run_grant = (state_q == ST_RUN);
  assign stop_req  = (state_q == ST_DOWN);

endmodule

// File: rtl/pdg_gate.sv
`timescale 1ns/1ps
module pdg_gate (
  input  logic clk_src,
  input  logic arst_n,
  input  logic allow,
  output logic clk_gated
);

  logic en_q;

  // Enable changes only while the source is low, so pulses stay whole.
  always_ff @(negedge clk_src or negedge arst_n) begin
    if (!arst_n) en_q <= 1'b0;
    else         en_q <= allow;
  end

  assign clk_gated = clk_src & en_q;

endmodule

// File: rtl/pdg_ctrl.sv
`timescale 1ns/1ps
module pdg_ctrl #(
  parameter int                 NUM_OUT    = 4,
  parameter logic [NUM_OUT-1:0] FREE_MASK  = 4'b0100,
  parameter int                 SETTLE_CYC = 12
) (
  input  logic               cpu_clk,
  input  logic               rst_n,
  input  logic               pd_n,
  input  logic [NUM_OUT-1:0] clk_in,
  input  logic [NUM_OUT-1:0] reg_en,
  output logic [NUM_OUT-1:0] clk_out,
  output logic               osc_stop,
  output logic               vco_stop
);

  logic rst_meta_q, rst_sync_q;
  logic accept, release_seen;
  logic run_grant, stop_req;

  always_ff @(posedge cpu_clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  pdg_pd_sampler i_sampler (
    .clk          (cpu_clk),
    .rst_n        (rst_sync_q),
    .pd_n         (pd_n),
    .accept       (accept),
    .release_seen (release_seen)
  );

  pdg_seq #(.SETTLE_CYC(SETTLE_CYC)) i_seq (
    .clk          (cpu_clk),
    .rst_n        (rst_sync_q),
    .accept       (accept),
    .release_seen (release_seen),
    .run_grant    (run_grant),
    .stop_req     (stop_req)
  );

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    logic allow;
    assign allow = run_grant & (reg_en[g] | FREE_MASK[g]);
    pdg_gate i_gate (
      .clk_src   (clk_in[g]),
      .arst_n    (rst_n),
      .allow     (allow),
      .clk_gated (clk_out[g])
    );
  end

  assign osc_stop = stop_req;
  assign vco_stop = stop_req;

endmodule

// File: rtl/pdg_ctrl_chk.sv
`timescale 1ns/1ps
module pdg_ctrl_chk #(
  parameter int NUM_OUT    = 4,
  parameter int SETTLE_CYC = 12
) (
  input logic               cpu_clk,
  input logic               rst_n,
  input logic               pd_n,
  input logic [NUM_OUT-1:0] clk_out,
  input logic               osc_stop
);

  localparam int QW = $clog2(SETTLE_CYC + 2);
  localparam logic [QW-1:0] QLIM = QW'(SETTLE_CYC);

  logic [3:0]    down_cnt_q;
  logic [QW-1:0] quiet_cnt_q;

  always_ff @(posedge cpu_clk or negedge rst_n) begin
    if (!rst_n) begin
      down_cnt_q  <= '0;
      quiet_cnt_q <= '0;
    end else begin
      if (!osc_stop)               down_cnt_q <= '0;
      else if (down_cnt_q != 4'd8) down_cnt_q <= down_cnt_q + 1'b1;
      if (osc_stop)                quiet_cnt_q <= '0;
      else if (quiet_cnt_q < QLIM) quiet_cnt_q <= quiet_cnt_q + 1'b1;
    end
  end

  AST_ENTRY_TWO_SAMPLES: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    $rose(osc_stop) |-> (!$past(pd_n, 2) && !$past(pd_n, 3))); // R2

  AST_DOWN_ALL_LOW: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    (osc_stop && down_cnt_q == 4'd8) |-> (clk_out == '0)); // R4

  AST_RELEASE_DROP: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    $fell(osc_stop) |-> $past(pd_n, 2)); // R6

  AST_SETTLE_QUIET: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    (!osc_stop && quiet_cnt_q < QLIM) |-> (clk_out == '0)); // R7

endmodule

bind pdg_ctrl pdg_ctrl_chk #(.NUM_OUT(NUM_OUT), .SETTLE_CYC(SETTLE_CYC)) i_chk (
  .cpu_clk  (cpu_clk),
  .rst_n    (rst_n),
  .pd_n     (pd_n),
  .clk_out  (clk_out),
  .osc_stop (osc_stop)
);

// File: tb/test_pdg_ctrl.sv
`timescale 1ns/1ps
module test_pdg_ctrl;

  localparam int N = 4;

  logic         cpu_clk = 1'b0;
  logic         rst_n;
  logic         pd_n;
  logic [N-1:0] clk_in = '0;
  logic [N-1:0] reg_en;
  logic [N-1:0] clk_out;
  logic         osc_stop, vco_stop;

  int checks = 0;
  int errors = 0;

  pdg_ctrl i_pdg_ctrl (
    .cpu_clk (cpu_clk), .rst_n (rst_n), .pd_n (pd_n),
    .clk_in (clk_in), .reg_en (reg_en), .clk_out (clk_out),
    .osc_stop (osc_stop), .vco_stop (vco_stop)
  );

  always #5 cpu_clk = ~cpu_clk;
  initial begin #1; forever #5  clk_in[0] = ~clk_in[0]; end
  initial begin #2; forever #10 clk_in[1] = ~clk_in[1]; end
  initial begin #3; forever #15 clk_in[2] = ~clk_in[2]; end
  initial begin #4; forever #35 clk_in[3] = ~clk_in[3]; end

  function automatic real hp_of(int i);
    case (i)
      0: return 5.0;
      1: return 10.0;
      2: return 15.0;
      default: return 35.0;
    endcase
  endfunction

  // Pulse-width monitor and edge counters, one per output (R5)
  int  rise_cnt [N];
  real t_rise   [N];
  bit  seen     [N];
  for (genvar g = 0; g < N; g++) begin : g_mon
    initial begin rise_cnt[g] = 0; seen[g] = 1'b0; end
    always @(posedge clk_out[g]) begin
      t_rise[g]   = $realtime;
      seen[g]     = 1'b1;
      rise_cnt[g] = rise_cnt[g] + 1;
    end
    always @(negedge clk_out[g]) begin
      if (seen[g]) begin
        real w;
        w = $realtime - t_rise[g];
        checks++;
        if (w < hp_of(g) - 0.01 || w > hp_of(g) + 0.01) begin
          errors++;
          $display("FAIL R5 out%0d high width actual=%0.2f expected=%0.2f", g, w, hp_of(g));
        end
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard: the driver pushes expected window results, the monitor measures them
  typedef struct {
    string        tag;
    logic         stop;
    logic [N-1:0] act;
  } exp_t;
  exp_t exp_q[$];
  event go_ev, done_ev;

  initial begin
    forever begin
      exp_t         it;
      int           base [N];
      logic [N-1:0] seen_act;
      @(go_ev);
      it = exp_q.pop_front();
      for (int i = 0; i < N; i++) base[i] = rise_cnt[i];
      chk({it.tag, " stop at window start"}, {31'd0, osc_stop}, {31'd0, it.stop});
      repeat (8) @(posedge cpu_clk);
      #3;
      for (int i = 0; i < N; i++) seen_act[i] = (rise_cnt[i] != base[i]);
      chk({it.tag, " output activity"}, {28'd0, seen_act}, {28'd0, it.act});
      chk({it.tag, " stop at window end"}, {31'd0, osc_stop}, {31'd0, it.stop});
      chk({it.tag, " vco stop follows"}, {31'd0, vco_stop}, {31'd0, it.stop});
      -> done_ev;
    end
  end

  task automatic expect_win(string tag, logic stop, logic [N-1:0] act);
    exp_t it;
    it.tag = tag; it.stop = stop; it.act = act;
    exp_q.push_back(it);
    -> go_ev;
    @(done_ev);
  endtask

  task automatic step(int n);
    repeat (n) @(posedge cpu_clk);
    #3;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; pd_n = 1'b1; reg_en = 4'hF;
    step(3);
    chk("R1 stop in reset", {31'd0, osc_stop}, 32'd0);
    chk("R1 outputs in reset", {28'd0, clk_out}, 32'd0);
    rst_n = 1'b1;
    expect_win("R1 quiet after reset", 1'b0, 4'b0000);
    step(12);
    expect_win("R8 all enabled run", 1'b0, 4'b1111);

    // R3: single low sample is ignored
    pd_n = 1'b0; step(1); pd_n = 1'b1;
    step(1); chk("R3 stop after one sample", {31'd0, osc_stop}, 32'd0);
    expect_win("R3 outputs keep running", 1'b0, 4'b1111);

    // R2: two samples then stop on the third edge
    step(1); pd_n = 1'b0;
    step(1); chk("R2 stop after first edge", {31'd0, osc_stop}, 32'd0);
    step(1); chk("R2 stop after second edge", {31'd0, osc_stop}, 32'd0);
    step(1); chk("R2 stop after third edge", {31'd0, osc_stop}, 32'd1);
    step(6);
    expect_win("R4 all low in power-down", 1'b1, 4'b0000);

    // R6 release, R7 settle
    pd_n = 1'b1;
    step(1); chk("R6 stop after first high sample", {31'd0, osc_stop}, 32'd1);
    step(1); chk("R6 stop dropped", {31'd0, osc_stop}, 32'd0);
    expect_win("R7 quiet during settle", 1'b0, 4'b0000);
    step(12);
    expect_win("R7 resume after settle", 1'b0, 4'b1111);

    // R8 and R9: register enables and free-running output
    reg_en = 4'b0101; step(10);
    expect_win("R8 partial enables", 1'b0, 4'b0101);
    reg_en = 4'b0000; step(10);
    expect_win("R9 free output ignores enable", 1'b0, 4'b0100);
    reg_en = 4'hF; step(10);

    // R10: re-entry during settle
    pd_n = 1'b0; step(3);
    chk("R10 first entry", {31'd0, osc_stop}, 32'd1);
    step(4);
    pd_n = 1'b1; step(2);
    chk("R10 released", {31'd0, osc_stop}, 32'd0);
    pd_n = 1'b0;
    step(1); chk("R10 settle first edge", {31'd0, osc_stop}, 32'd0);
    step(1); chk("R10 settle second edge", {31'd0, osc_stop}, 32'd0);
    step(1); chk("R10 re-entered", {31'd0, osc_stop}, 32'd1);
    step(5);
    expect_win("R10 all low again", 1'b1, 4'b0000);
    pd_n = 1'b1; step(20);
    expect_win("R10 recovered", 1'b0, 4'b1111);

    finish_run();
  end

endmodule